// File: doc/BRIEF.md
# Receive Payload Trigger-Size Partitioner

This block sits between the receive datapath and the receive FIFO. It takes the payload of a received packet (header CRC and data CRC already removed upstream) as a stream of 32-bit quadlets. It writes that payload into the FIFO as one or more blocks. Every block starts with a token quadlet that carries the number of payload quadlets following it in that block. Each finished block raises a one-cycle data-ready interrupt. The host can therefore start reading part of a packet that is larger than the FIFO, without waiting for the whole packet to arrive.

When partitioning is active, blocks hold at most `trig_size` payload quadlets. Partitioning is active only when the enable bit is set, the flush-bad bit is clear and the trigger size is non-zero. When it is not active, the whole packet is one block, subject to the holding-buffer depth. The token must reach the FIFO before its data. Each block is therefore first collected in a holding buffer of `DEPTH` quadlets and only then written out.

The input is a valid/ready stream. A beat transfers in a cycle where `in_valid` and `in_ready` are both high, and the source must hold its beat stable until then. `in_ready` is low while a block is being written out and whenever `fifo_full` is high. The FIFO side is write-only: a quadlet is written in each cycle where `fifo_we` is high, and `fifo_we` is never raised while `fifo_full` is high.

Top module: `rtp_partitioner`

## Requirements
- R1: While reset is held, and in the first cycle after it ends, `fifo_we` and `blk_irq` are low. After reset, `in_ready` is high while `fifo_full` is low.
- R2: With partitioning active and trigger size N, a packet of L payload quadlets is written as ceil(L/N) blocks. Every block except the last carries exactly N payload quadlets (a 20-quadlet packet with N=8 gives blocks of 9, 9 and 5 FIFO quadlets, token included).
- R3: Each block is one token quadlet followed by its payload quadlets in arrival order. The token holds the payload count of that block, zero-extended from bit 0 upward.
- R4: `blk_irq` is a single-cycle pulse, raised exactly once per block, in the same cycle as the FIFO write of that block's last payload quadlet.
- R5: With `flush_bad` high, partitioning is off whatever `trig_en` and `trig_size` hold.
- R6: With `trig_en` low or `trig_size` zero, a packet is written as a single block with one token and one interrupt.
- R7: No block exceeds `DEPTH` payload quadlets. A non-partitioned packet longer than `DEPTH` is cut into `DEPTH`-quadlet blocks, and a trigger size above `DEPTH` acts as `DEPTH`.
- R8: `fifo_we` is never high while `fifo_full` is high. `fifo_full` holds `in_ready` low and pauses the write-out, and no quadlet is lost or repeated.
- R9: `in_ready` is low in every cycle in which `fifo_we` is high.
- R10: `trig_en`, `flush_bad` and `trig_size` are sampled on the beat marked `in_sop`. Later changes within the packet do not alter its block layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_data | input | DW | Payload quadlet |
| in_sop | input | 1 | First quadlet of a packet payload |
| in_eop | input | 1 | Last quadlet of a packet payload |
| trig_size | input | TSW | Block size in quadlets, 0 = no partitioning |
| trig_en | input | 1 | Partitioning enable |
| flush_bad | input | 1 | Bad-packet flush mode; forces partitioning off |
| fifo_full | input | 1 | Receive FIFO cannot take a write |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | DW | Token or payload quadlet to the FIFO |
| blk_irq | output | 1 | Data-ready pulse, one per block |

## Verification
A wrong fill count or limit register shows up at the FIFO port at the next token. The token value or the block length disagrees with the expected split within one block time of the trigger boundary. A wrong read index shows up as a repeated, skipped or reordered payload quadlet in the same write-out. A stuck state shows up as `in_ready` staying low with no FIFO writes, which the bench catches while it waits for the expected write count. Tests under heavy `fifo_full` back-pressure and with mid-packet setting changes make a lost stall or a re-sampled limit visible in the block layout of that packet.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
  typedef enum logic [1:0] {
    S_FILL  = 2'd0,
    S_TOKEN = 2'd1,
    S_DATA  = 2'd2
  } rtp_state_e;
endpackage

// File: rtl/rtp_limit.sv
module rtp_limit #(
  parameter int TSW   = 8,
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input  logic [TSW-1:0] trig_size,
  input  logic           trig_en,
  input  logic           flush_bad,
  output logic [CW-1:0]  lim
);
  logic part_on;
  // flush mode overrides the enable; size zero means no split
  assign part_on = trig_en && !flush_bad && (trig_size != '0);

  generate
    if (((1 << TSW) - 1) > DEPTH) begin : g_clamp
      assign lim = !part_on                   ? CW'(DEPTH) :
                   (int'(trig_size) > DEPTH)  ? CW'(DEPTH) :
                                                CW'(trig_size);
    end else begin : g_direct
      assign lim = part_on ? CW'(trig_size) : CW'(DEPTH);
    end
  endgenerate
endmodule

// File: rtl/rtp_hold_buf.sv
module rtp_hold_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rtp_seq.sv
module rtp_seq
  import rtp_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW    = 9,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [CW-1:0] lim_eff,
  input  logic          fifo_full,
  output logic          in_ready,
  output logic          buf_we,
  output logic [AW-1:0] buf_waddr,
  output logic [AW-1:0] buf_raddr,
  output logic          fifo_we,
  output logic          tok_sel,
  output logic [CW-1:0] tok_val,
  output logic          blk_irq
);
  rtp_state_e    st;
  logic [CW-1:0] cnt, lim_q, blen;
  logic [AW-1:0] rd;
  logic [CW-1:0] cnt_nxt, lim_now;
  logic          accept, rd_last;

  assign accept  = in_valid && in_ready;
  assign cnt_nxt = cnt + CW'(1);
  assign lim_now = in_sop ? lim_eff : lim_q;   // settings taken at packet start
  assign rd_last = (CW'(rd) == blen - CW'(1));

  assign in_ready  = (st == S_FILL) && !fifo_full;
  assign fifo_we   = (st != S_FILL) && !fifo_full;
  assign tok_sel   = (st == S_TOKEN);
  assign tok_val   = blen;
  assign blk_irq   = (st == S_DATA) && !fifo_full && rd_last;
  assign buf_we    = accept;
  assign buf_waddr = cnt[AW-1:0];
  assign buf_raddr = rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_FILL;
      cnt   <= '0;
      lim_q <= CW'(DEPTH);
      blen  <= '0;
      rd    <= '0;
    end else begin
      unique case (st)
        S_FILL: if (accept) begin
          if (in_sop) lim_q <= lim_eff;
          cnt <= cnt_nxt;
          if (in_eop || cnt_nxt == lim_now) begin
            blen <= cnt_nxt;
            st   <= S_TOKEN;
          end
        end
        S_TOKEN: if (!fifo_full) begin
          rd <= '0;
          st <= S_DATA;
        end
        S_DATA: if (!fifo_full) begin
          if (rd_last) begin
            cnt <= '0;
            st  <= S_FILL;
          end else begin
            rd <= rd + AW'(1);
          end
        end
        default: st <= S_FILL;
      endcase
    end
  end

  // R2 / R7: a closed block is never empty and never larger than its limit
  a_r2_block_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TOKEN) |-> (blen != '0 && blen <= lim_q && int'(blen) <= DEPTH));

  // R3: the read index stays inside the block being written out
  a_r3_rd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (CW'(rd) < blen));
endmodule

// File: rtl/rtp_partitioner.sv
module rtp_partitioner #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  parameter int TSW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  input  logic           in_sop,
  input  logic           in_eop,
  input  logic [TSW-1:0] trig_size,
  input  logic           trig_en,
  input  logic           flush_bad,
  input  logic           fifo_full,
  output logic           fifo_we,
  output logic [DW-1:0]  fifo_wdata,
  output logic           blk_irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] lim_eff, tok_val;
  logic          buf_we, tok_sel;
  logic [AW-1:0] buf_waddr, buf_raddr;
  logic [DW-1:0] buf_rdata;

  rtp_limit #(.TSW(TSW), .DEPTH(DEPTH), .CW(CW)) u_limit (
    .trig_size (trig_size),
    .trig_en   (trig_en),
    .flush_bad (flush_bad),
    .lim       (lim_eff)
  );

  rtp_seq #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .lim_eff   (lim_eff),
    .fifo_full (fifo_full),
    .in_ready  (in_ready),
    .buf_we    (buf_we),
    .buf_waddr (buf_waddr),
    .buf_raddr (buf_raddr),
    .fifo_we   (fifo_we),
    .tok_sel   (tok_sel),
    .tok_val   (tok_val),
    .blk_irq   (blk_irq)
  );

  rtp_hold_buf #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (in_data),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  assign fifo_wdata = tok_sel ? DW'(tok_val) : buf_rdata;

  // R8: no write into a full FIFO
  a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_we);

  // R9: input and output phases never overlap
  a_r9_no_accept_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> !in_ready);

  // R4: interrupt only alongside a FIFO write
  a_r4_irq_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    blk_irq |-> fifo_we);

  // R4: a token write always separates two interrupts
  a_r4_irq_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    blk_irq |=> !blk_irq);
endmodule

// File: tb/sim_rtp_partitioner.sv
`timescale 1ns/1ps
module sim_rtp_partitioner;
  localparam int DW = 32, DEPTH = 16, TSW = 8;
  localparam int NV = 10;
  // vector table: length, trigger size, enable, flush-bad
  localparam int V_LEN [NV] = '{20, 5, 16, 7, 10, 12, 9, 1, 40, 20};
  localparam int V_TS  [NV] = '{ 8, 8,  4, 1,  3,  4, 0, 5,  0, 200};
  localparam bit V_EN  [NV] = '{ 1, 1,  1, 1,  1,  0, 1, 1,  0, 1};
  localparam bit V_FB  [NV] = '{ 0, 0,  0, 0,  1,  0, 0, 0,  0, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [TSW-1:0] trig_size = '0;
  logic trig_en = 1'b0, flush_bad = 1'b0, fifo_full = 1'b0;
  logic in_ready, fifo_we, blk_irq;
  logic [DW-1:0] fifo_wdata;

  always #2.5 clk = ~clk;

  rtp_partitioner #(.DW(DW), .DEPTH(DEPTH), .TSW(TSW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .trig_size(trig_size), .trig_en(trig_en), .flush_bad(flush_bad),
    .fifo_full(fifo_full), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
    .blk_irq(blk_irq));

  int total = 0, bad = 0, cyc = 0;
  int viol_full = 0, viol_rdy = 0;
  bit stall_mode = 1'b0, done = 1'b0;
  logic [DW-1:0] got_w[$], exp_w[$];
  int got_irq[$], exp_irq[$];

  always @(posedge clk) begin
    cyc++;
    if (fifo_we) got_w.push_back(fifo_wdata);
    if (blk_irq) got_irq.push_back(got_w.size() - 1);
    if (fifo_we && fifo_full) viol_full++;
    if (fifo_we && in_ready) viol_rdy++;
  end

  always @(negedge clk) fifo_full = stall_mode ? ((cyc % 3) != 0) : 1'b0;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int eff_lim(int ts, bit en, bit fb);
    if (en && !fb && ts != 0) return (ts > DEPTH) ? DEPTH : ts;
    return DEPTH;
  endfunction

  task automatic build_exp(int len, int lim, int base);
    int i = 0;
    exp_w.delete(); exp_irq.delete();
    while (i < len) begin
      int n = (len - i < lim) ? len - i : lim;
      exp_w.push_back(DW'(n));
      for (int j = 0; j < n; j++) exp_w.push_back(DW'(base + i + j));
      exp_irq.push_back(exp_w.size() - 1);
      i += n;
    end
  endtask

  task automatic send_pkt(int len, int ts, bit en, bit fb, int base, int chg_at);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      if (b == 0) begin
        trig_size = TSW'(ts); trig_en = en; flush_bad = fb;
      end
      if (b == chg_at) begin
        trig_size = TSW'(2); trig_en = 1'b1; flush_bad = 1'b0;
      end
      in_valid = 1'b1; in_data = DW'(base + b);
      in_sop = (b == 0); in_eop = (b == len - 1);
      forever begin
        #1;
        if (in_ready) break;
        @(negedge clk);
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic run_pkt(int len, int ts, bit en, bit fb, int base, int chg_at, string req);
    int w = 0;
    int first_bad = -1;
    int n_irq_ok;
    got_w.delete(); got_irq.delete();
    build_exp(len, eff_lim(ts, en, fb), base);
    send_pkt(len, ts, en, fb, base, chg_at);
    while (got_w.size() < exp_w.size() && w < 3000) begin
      @(negedge clk); w++;
    end
    repeat (4) @(negedge clk);
    chk(got_w.size() == exp_w.size(), req, "fifo write count", got_w.size(), exp_w.size());
    for (int k = 0; k < exp_w.size() && k < got_w.size(); k++)
      if (first_bad < 0 && got_w[k] !== exp_w[k]) first_bad = k;
    chk(first_bad < 0, req, "fifo word (R3 token/data order)",
        (first_bad < 0) ? 0 : int'(got_w[first_bad]),
        (first_bad < 0) ? 0 : int'(exp_w[first_bad]));
    n_irq_ok = (got_irq.size() == exp_irq.size());
    for (int k = 0; k < exp_irq.size() && n_irq_ok; k++)
      if (got_irq[k] != exp_irq[k]) n_irq_ok = 0;
    chk(n_irq_ok != 0, req, "R4 interrupt count/position", got_irq.size(), exp_irq.size());
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(fifo_we == 1'b0 && blk_irq == 1'b0, "R1", "outputs during reset", int'({fifo_we, blk_irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(fifo_we == 1'b0 && blk_irq == 1'b0, "R1", "outputs after reset", int'({fifo_we, blk_irq}), 0);

    // table walk: R2 split, R5 flush override, R6 single block, R7 depth limit
    for (int v = 0; v < NV; v++)
      run_pkt(V_LEN[v], V_TS[v], V_EN[v], V_FB[v], (v + 1) << 12, -1,
              (v == 4) ? "R5" : (v == 5 || v == 6) ? "R6" : (v >= 8) ? "R7" : "R2");

    // R10: settings changed mid-packet are ignored for that packet
    run_pkt(12, 6, 1'b1, 1'b0, 32'h0000_B000, 6, "R10");
    // R10: setting at sop of next packet takes effect
    run_pkt(6, 2, 1'b1, 1'b0, 32'h0000_C000, -1, "R10");

    // R8: heavy back-pressure from the FIFO
    stall_mode = 1'b1;
    run_pkt(20, 8, 1'b1, 1'b0, 32'h0000_D000, -1, "R8");
    run_pkt(20, 200, 1'b1, 1'b0, 32'h0000_E000, -1, "R8");
    stall_mode = 1'b0;
    @(negedge clk);

    chk(viol_full == 0, "R8", "writes while full", viol_full, 0);
    chk(viol_rdy == 0, "R9", "ready during write", viol_rdy, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule